// File: doc/BRIEF.md
# Boundary-Scan Pad Cell Chain

This block sits between a chip's core logic and its pad ring for a small group of peripheral pins. It inserts one scan cell on every single-bit signal that crosses the boundary. A bidirectional pin is modelled as three separate signals: pad input, pad output and pad output-enable, and each gets its own cell. An input-only pin and an output-only pin each contribute one cell. Every cell has a shift stage, which is part of a serial chain, and an update latch that holds a value parallel to the chain.

A test access controller outside this block drives the block's strobes: capture, shift and update, plus an external-test select. The chain takes serial data at `scanIn` and delivers it at `scanOut`.

The block has two modes:
- **External-test mode.** The core is isolated from the pads. The pads are driven from the update latches, and the core sees latched values in place of pad inputs.
- **Normal or sample mode.** Core and pads stay connected straight through. Capture takes a snapshot of every live signal without disturbing traffic.

Top module: `bscan_pad_chain`

## Requirements
- R1: The serial path holds LEN = NI + NO + 3*NB cells. A bit presented at `scanIn` on a shift edge first appears at `scanOut` after exactly LEN shift edges.
- R2: Cell order, counted from `scanIn` as index 0, is fixed:
  - indices 0..NI-1 are the input-only pins;
  - the next NB cells are the bidirectional pad inputs;
  - the next NO cells are the output-only pins;
  - the next NB cells are the bidirectional outputs;
  - the last NB cells are the bidirectional enables.
  `scanOut` is the shift stage of cell LEN-1, which is the enable of bidirectional pin NB-1.
- R3: On a capture edge, input-direction cells load the pad-side value, and output and enable cells load the core-side value. When capture and shift are both asserted, capture wins.
- R4: Update latches change only on an edge where `updateEn` is high. In external-test mode, the pad-driven outputs and the core-side inputs stay constant while the chain shifts or captures.
- R5: In external-test mode:
  - `padTx`, `padBiOut` and `padBiOe` come from the update latches of their cells;
  - `coreRx` and `coreBiIn` come from the update latches of the input cells, not from the pads.
- R6: Outside external-test mode, every pad output equals its core output and every core input equals its pad input. Capture, shift and update do not change this.
- R7: Reset (`rstN` low, asynchronous) clears every shift stage and update latch, so pad enables are 0 in external-test mode and `scanOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rstN | input | 1 | Asynchronous reset, active low |
| captureEn | input | 1 | Capture strobe |
| shiftEn | input | 1 | Shift strobe |
| updateEn | input | 1 | Update strobe |
| extestMode | input | 1 | 1 = core isolated, pads driven from latches |
| scanIn | input | 1 | Serial data into cell 0 |
| scanOut | output | 1 | Serial data from cell LEN-1 |
| padRx | input | NI | Pad side of input-only pins |
| coreRx | output | NI | Core side of input-only pins |
| coreTx | input | NO | Core side of output-only pins |
| padTx | output | NO | Pad side of output-only pins |
| padBiIn | input | NB | Pad input of bidirectional pins |
| coreBiIn | output | NB | Core input of bidirectional pins |
| coreBiOut | input | NB | Core output of bidirectional pins |
| coreBiOe | input | NB | Core output-enable of bidirectional pins |
| padBiOut | output | NB | Pad output of bidirectional pins |
| padBiOe | output | NB | Pad output-enable of bidirectional pins |

## Verification
The mode multiplexing is combinational, so pass-through and latch-driven values are due in the same cycle as a change of inputs or mode. `scanOut` and the latched pad values are due one edge after a capture, shift or update strobe. A single marked bit reaches `scanOut` exactly LEN shift edges after it enters, or LEN-1-index shift edges after a capture loads it into cell `index`.

The bench drives its inputs two time units after a rising edge and takes its directed samples at that point. A behavioural model advances on the same rising edge and is compared with every output at each falling edge. As a result, no sample ever coincides with an edge.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  // Decoded strobes passed from control to datapath
  typedef struct packed {
    logic capture;
    logic shift;
    logic update;
    logic extest;
  } bscStrobe_t;
endpackage

// File: rtl/bscan_ctrl.sv
module bscan_ctrl
  import bscan_pkg::*;
(
  input  logic       captureEn,
  input  logic       shiftEn,
  input  logic       updateEn,
  input  logic       extestMode,
  output bscStrobe_t strobe
);
  // Capture has priority over shift (R3); update is independent
  always_comb begin
    strobe.capture = captureEn;
    strobe.shift   = shiftEn & ~captureEn;
    strobe.update  = updateEn;
    strobe.extest  = extestMode;
  end
endmodule

// File: rtl/bscan_datapath.sv
module bscan_datapath
  import bscan_pkg::*;
#(
  parameter int NI = 1,
  parameter int NO = 1,
  parameter int NB = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  bscStrobe_t    strobe,
  input  logic          scanIn,
  output logic          scanOut,
  input  logic [NI-1:0] padRx,
  output logic [NI-1:0] coreRx,
  input  logic [NO-1:0] coreTx,
  output logic [NO-1:0] padTx,
  input  logic [NB-1:0] padBiIn,
  output logic [NB-1:0] coreBiIn,
  input  logic [NB-1:0] coreBiOut,
  input  logic [NB-1:0] coreBiOe,
  output logic [NB-1:0] padBiOut,
  output logic [NB-1:0] padBiOe
);
  localparam int LEN      = NI + NO + 3 * NB;
  localparam int OFS_BIN  = NI;
  localparam int OFS_OUT  = NI + NB;
  localparam int OFS_BOUT = OFS_OUT + NO;
  localparam int OFS_BOE  = OFS_BOUT + NB;

  logic [LEN-1:0] capVec;
  logic [LEN-1:0] shiftQ;
  logic [LEN-1:0] updQ;

  // Inputs nearest scanIn, outputs then enables nearest scanOut (R2)
  assign capVec = {coreBiOe, coreBiOut, coreTx, padBiIn, padRx};

  for (genvar i = 0; i < LEN; i++) begin : g_cell
    logic serIn;
    logic shiftBit;
    logic updBit;

    if (i == 0) begin : g_head
      assign serIn = scanIn;
    end else begin : g_link
      assign serIn = shiftQ[i-1];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shiftBit <= 1'b0;
      end else if (strobe.capture) begin
        shiftBit <= capVec[i];
      end else if (strobe.shift) begin
        shiftBit <= serIn;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        updBit <= 1'b0;
      end else if (strobe.update) begin
        updBit <= shiftBit;
      end
    end

    assign shiftQ[i] = shiftBit;
    assign updQ[i]   = updBit;
  end

  assign scanOut = shiftQ[LEN-1];

  // Mode multiplexing between core, pads and update latches
  assign coreRx   = strobe.extest ? updQ[0 +: NI]        : padRx;
  assign coreBiIn = strobe.extest ? updQ[OFS_BIN +: NB]  : padBiIn;
  assign padTx    = strobe.extest ? updQ[OFS_OUT +: NO]  : coreTx;
  assign padBiOut = strobe.extest ? updQ[OFS_BOUT +: NB] : coreBiOut;
  assign padBiOe  = strobe.extest ? updQ[OFS_BOE +: NB]  : coreBiOe;
endmodule

// File: rtl/bscan_pad_chain.sv
module bscan_pad_chain
  import bscan_pkg::*;
#(
  parameter int NI = 1,
  parameter int NO = 1,
  parameter int NB = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          captureEn,
  input  logic          shiftEn,
  input  logic          updateEn,
  input  logic          extestMode,
  input  logic          scanIn,
  output logic          scanOut,
  input  logic [NI-1:0] padRx,
  output logic [NI-1:0] coreRx,
  input  logic [NO-1:0] coreTx,
  output logic [NO-1:0] padTx,
  input  logic [NB-1:0] padBiIn,
  output logic [NB-1:0] coreBiIn,
  input  logic [NB-1:0] coreBiOut,
  input  logic [NB-1:0] coreBiOe,
  output logic [NB-1:0] padBiOut,
  output logic [NB-1:0] padBiOe
);
  bscStrobe_t strobe;

  bscan_ctrl ctrl_i (
    .captureEn (captureEn),
    .shiftEn   (shiftEn),
    .updateEn  (updateEn),
    .extestMode(extestMode),
    .strobe    (strobe)
  );

  bscan_datapath #(.NI(NI), .NO(NO), .NB(NB)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .scanIn   (scanIn),
    .scanOut  (scanOut),
    .padRx    (padRx),
    .coreRx   (coreRx),
    .coreTx   (coreTx),
    .padTx    (padTx),
    .padBiIn  (padBiIn),
    .coreBiIn (coreBiIn),
    .coreBiOut(coreBiOut),
    .coreBiOe (coreBiOe),
    .padBiOut (padBiOut),
    .padBiOe  (padBiOe)
  );
endmodule

// File: rtl/bscan_pad_chain_chk.sv
module bscan_pad_chain_chk #(
  parameter int NI = 1,
  parameter int NO = 1,
  parameter int NB = 6
) (
  input logic          clk,
  input logic          rstN,
  input logic          captureEn,
  input logic          updateEn,
  input logic          extestMode,
  input logic          scanOut,
  input logic [NI-1:0] padRx,
  input logic [NI-1:0] coreRx,
  input logic [NO-1:0] coreTx,
  input logic [NO-1:0] padTx,
  input logic [NB-1:0] padBiIn,
  input logic [NB-1:0] coreBiIn,
  input logic [NB-1:0] coreBiOut,
  input logic [NB-1:0] coreBiOe,
  input logic [NB-1:0] padBiOut,
  input logic [NB-1:0] padBiOe
);
  // R6: transparent connection outside external-test mode
  p_pass_through_r6: assert property (@(posedge clk) disable iff (!rstN)
    !extestMode |-> (padBiOut == coreBiOut && padBiOe == coreBiOe &&
                     padTx == coreTx && coreRx == padRx && coreBiIn == padBiIn));

  // R4: latched values hold without an update strobe
  p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (extestMode && !updateEn) |=> (!extestMode ||
      ($stable(padBiOut) && $stable(padBiOe) && $stable(padTx) &&
       $stable(coreRx) && $stable(coreBiIn))));

  // R3/R2: capture loads the last cell (last enable) from the core side
  p_capture_tail_r3: assert property (@(posedge clk) disable iff (!rstN)
    captureEn |=> scanOut == $past(coreBiOe[NB-1]));

  // R7: pad enables inactive in external-test mode while in reset
  always @(posedge clk) begin
    if (!rstN && extestMode) begin
      p_reset_oe_r7: assert (padBiOe == '0);
    end
  end
endmodule

bind bscan_pad_chain bscan_pad_chain_chk #(.NI(NI), .NO(NO), .NB(NB)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .captureEn (captureEn),
  .updateEn  (updateEn),
  .extestMode(extestMode),
  .scanOut   (scanOut),
  .padRx     (padRx),
  .coreRx    (coreRx),
  .coreTx    (coreTx),
  .padTx     (padTx),
  .padBiIn   (padBiIn),
  .coreBiIn  (coreBiIn),
  .coreBiOut (coreBiOut),
  .coreBiOe  (coreBiOe),
  .padBiOut  (padBiOut),
  .padBiOe   (padBiOe)
);

// File: tb/bscan_pad_chain_tb.sv
module bscan_pad_chain_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NI  = 1;
  localparam int NO  = 1;
  localparam int NB  = 6;
  localparam int LEN = NI + NO + 3 * NB;
  localparam int I_BIN  = NI;
  localparam int I_OUT  = NI + NB;
  localparam int I_BOUT = NI + NB + NO;
  localparam int I_BOE  = NI + 2 * NB + NO;

  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic captureEn = 1'b0, shiftEn = 1'b0, updateEn = 1'b0, extestMode = 1'b0;
  logic scanIn = 1'b0;
  logic scanOut;
  logic [NI-1:0] padRx = '0;
  logic [NI-1:0] coreRx;
  logic [NO-1:0] coreTx = '0;
  logic [NO-1:0] padTx;
  logic [NB-1:0] padBiIn = '0;
  logic [NB-1:0] coreBiIn;
  logic [NB-1:0] coreBiOut = '0;
  logic [NB-1:0] coreBiOe = '0;
  logic [NB-1:0] padBiOut;
  logic [NB-1:0] padBiOe;

  int nChecks = 0;
  int nFails  = 0;
  bit done = 1'b0;

  bscan_pad_chain #(.NI(NI), .NO(NO), .NB(NB)) dut_i (
    .clk(clk), .rstN(rstN), .captureEn(captureEn), .shiftEn(shiftEn),
    .updateEn(updateEn), .extestMode(extestMode), .scanIn(scanIn),
    .scanOut(scanOut), .padRx(padRx), .coreRx(coreRx), .coreTx(coreTx),
    .padTx(padTx), .padBiIn(padBiIn), .coreBiIn(coreBiIn),
    .coreBiOut(coreBiOut), .coreBiOe(coreBiOe), .padBiOut(padBiOut),
    .padBiOe(padBiOe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- Behavioural reference model ----------------
  bit mShift[$];
  bit mUpd[LEN];

  function automatic bit capBit(int i);
    if (i < I_BIN)       return padRx[i];
    else if (i < I_OUT)  return padBiIn[i - I_BIN];
    else if (i < I_BOUT) return coreTx[i - I_OUT];
    else if (i < I_BOE)  return coreBiOut[i - I_BOUT];
    else                 return coreBiOe[i - I_BOE];
  endfunction

  initial begin
    for (int i = 0; i < LEN; i++) mShift.push_back(1'b0);
  end

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LEN; i++) begin
        mShift[i] = 1'b0;
        mUpd[i] = 1'b0;
      end
    end else begin
      bit old[LEN];
      for (int i = 0; i < LEN; i++) old[i] = mShift[i];
      if (captureEn) begin
        for (int i = 0; i < LEN; i++) mShift[i] = capBit(i);
      end else if (shiftEn) begin
        mShift.push_front(scanIn);
        void'(mShift.pop_back());
      end
      if (updateEn) begin
        for (int i = 0; i < LEN; i++) mUpd[i] = old[i];
      end
    end
  end

  // Compare every output against the model at each falling edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      logic [NB-1:0] eOut, eOe, eBin;
      logic [NO-1:0] eTx;
      logic [NI-1:0] eRx;
      for (int j = 0; j < NB; j++) begin
        eOut[j] = extestMode ? mUpd[I_BOUT + j] : coreBiOut[j];
        eOe[j]  = extestMode ? mUpd[I_BOE + j]  : coreBiOe[j];
        eBin[j] = extestMode ? mUpd[I_BIN + j]  : padBiIn[j];
      end
      for (int j = 0; j < NO; j++) eTx[j] = extestMode ? mUpd[I_OUT + j] : coreTx[j];
      for (int j = 0; j < NI; j++) eRx[j] = extestMode ? mUpd[j] : padRx[j];
      check("R1 model scanOut", 32'(scanOut), 32'(mShift[LEN-1]));
      check(extestMode ? "R5 model padBiOut" : "R6 model padBiOut", 32'(padBiOut), 32'(eOut));
      check(extestMode ? "R5 model padBiOe" : "R6 model padBiOe", 32'(padBiOe), 32'(eOe));
      check(extestMode ? "R5 model coreBiIn" : "R6 model coreBiIn", 32'(coreBiIn), 32'(eBin));
      check(extestMode ? "R5 model padTx" : "R6 model padTx", 32'(padTx), 32'(eTx));
      check(extestMode ? "R5 model coreRx" : "R6 model coreRx", 32'(coreRx), 32'(eRx));
    end
  end

  // ---------------- Stimulus helpers ----------------
  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  // Capture, then shift until the single set bit shows up; report shift count
  task automatic findMark(string req, int idx);
    int seen = -1;
    captureEn = 1'b1; shiftEn = 1'b0; scanIn = 1'b0;
    cyc();
    captureEn = 1'b0; shiftEn = 1'b1;
    for (int s = 0; s < LEN; s++) begin
      if (seen < 0 && scanOut == 1'b1) seen = s;
      cyc();
    end
    shiftEn = 1'b0;
    check(req, 32'(seen), 32'(LEN - 1 - idx));
  endtask

  task automatic shiftWord(logic [LEN-1:0] w);
    shiftEn = 1'b1;
    for (int k = LEN - 1; k >= 0; k--) begin
      scanIn = w[k];
      cyc();
    end
    shiftEn = 1'b0;
    scanIn = 1'b0;
  endtask

  // ---------------- Directed sequence ----------------
  initial begin
    logic [LEN-1:0] pat;
    logic [NB-1:0] oeHeld;
    for (int i = 0; i < LEN; i++) pat[i] = ((i % 3) == 0) ^ ((i % 2) == 1);

    // R7: reset state
    extestMode = 1'b1;
    coreBiOe = '1;
    #1 rstN = 1'b0;
    cyc(); cyc();
    check("R7 enables in reset", 32'(padBiOe), 32'(0));
    check("R7 scanOut in reset", 32'(scanOut), 32'(0));
    rstN = 1'b1;
    cyc();
    check("R7 enables after reset", 32'(padBiOe), 32'(0));
    check("R7 coreRx latch after reset", 32'(coreRx), 32'(0));

    // R1: chain length
    extestMode = 1'b0;
    coreBiOe = '0;
    shiftEn = 1'b1; scanIn = 1'b1;
    cyc();
    scanIn = 1'b0;
    for (int k = 2; k < LEN; k++) cyc();
    check("R1 not yet out after LEN-1 shifts", 32'(scanOut), 32'(0));
    cyc();
    check("R1 out after LEN shifts", 32'(scanOut), 32'(1));
    cyc();
    check("R1 gone after LEN+1 shifts", 32'(scanOut), 32'(0));
    shiftEn = 1'b0;

    // R3: capture beats shift, last cell is last enable
    coreBiOe = NB'(1) << (NB - 1);
    captureEn = 1'b1; shiftEn = 1'b1;
    cyc();
    captureEn = 1'b0; shiftEn = 1'b0;
    check("R3 capture priority", 32'(scanOut), 32'(1));
    coreBiOe = '0;

    // R2/R3: order and capture source of each cell class
    padRx = 1'b1;
    findMark("R2 input-only cell index", 0);
    padRx = '0;
    padBiIn = NB'(1) << 2;
    findMark("R2 bidir input cell index", I_BIN + 2);
    padBiIn = '0;
    coreTx = 1'b1;
    findMark("R3 output-only cell loads core", I_OUT);
    coreTx = '0;
    coreBiOut = NB'(1) << 3;
    findMark("R3 bidir output cell loads core", I_BOUT + 3);
    coreBiOut = '0;
    coreBiOe = NB'(1) << 1;
    findMark("R2 bidir enable cell index", I_BOE + 1);
    coreBiOe = '0;

    // R5: external test drives pads from latches
    extestMode = 1'b1;
    coreBiOut = '1; coreTx = '1;
    shiftWord(pat);
    updateEn = 1'b1;
    cyc();
    updateEn = 1'b0;
    check("R5 padBiOe from latch", 32'(padBiOe), 32'(pat[I_BOE +: NB]));
    check("R5 padBiOut from latch", 32'(padBiOut), 32'(pat[I_BOUT +: NB]));
    check("R5 padTx from latch", 32'(padTx), 32'(pat[I_OUT +: NO]));
    check("R5 coreRx from latch", 32'(coreRx), 32'(pat[0 +: NI]));
    padBiIn = ~pat[I_BIN +: NB];
    #1;
    check("R5 coreBiIn ignores pads", 32'(coreBiIn), 32'(pat[I_BIN +: NB]));

    // R4: no change while shifting/capturing without update
    oeHeld = padBiOe;
    shiftEn = 1'b1; scanIn = 1'b0;
    for (int k = 0; k < LEN; k++) begin
      cyc();
      if (k % 5 == 0) check("R4 enables hold during shift", 32'(padBiOe), 32'(oeHeld));
    end
    shiftEn = 1'b0;
    captureEn = 1'b1;
    cyc();
    captureEn = 1'b0;
    check("R4 enables hold after capture", 32'(padBiOe), 32'(oeHeld));
    shiftWord('0);
    updateEn = 1'b1;
    cyc();
    updateEn = 1'b0;
    check("R4 enables change on update", 32'(padBiOe), 32'(0));

    // R6: sample mode pass-through, capture does not disturb
    extestMode = 1'b0;
    coreBiOut = 6'b101101; coreBiOe = 6'b011010; padBiIn = 6'b110001;
    coreTx = 1'b0; padRx = 1'b1;
    #1;
    check("R6 padBiOut pass", 32'(padBiOut), 32'(6'b101101));
    check("R6 coreBiIn pass", 32'(coreBiIn), 32'(6'b110001));
    captureEn = 1'b1; updateEn = 1'b1;
    cyc();
    captureEn = 1'b0; updateEn = 1'b0;
    check("R6 padBiOe after capture", 32'(padBiOe), 32'(6'b011010));
    check("R6 coreRx after capture", 32'(coreRx), 32'(1));
    check("R6 padTx after capture", 32'(padTx), 32'(0));
    cyc(); cyc();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    nFails++;
    nChecks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule